// File: doc/BRIEF.md
# FPU High-Half Register Move Unit

This unit carries the upper 32 bits of a floating-point register across to the integer side, and back again. It holds a 32-entry, 64-bit floating-point register file with one read port and one write port. A single mode input chooses how a register's "high half" is found. In wide mode each register is a full 64-bit value and the high half is bits 63:32 of the named register. In paired mode each register holds a 32-bit value in its low half. An even register number then pairs with the next odd register, which supplies the high half.

Each cycle the pipeline may present one instruction word, a 32-bit integer operand, the mode bit and an FPU-enable bit. A move-from returns a sign-extended 64-bit result one cycle later, together with the destination field. A move-to updates the register file at the same clock edge.

Two cases do not fault:
- In paired mode, an odd register number yields fixed poison data and raises a one-cycle flag.
- A disabled FPU raises a one-cycle unusable flag and changes nothing.

Top module: `hmove_unit`

## Requirements
- R1: A word is accepted only when all of these hold: bits 31:26 = 010001, bits 10:0 = 0, and bits 25:21 = 00011 (move-from) or 00111 (move-to). In an accepted word, rt is bits 20:16 and fs is bits 15:11. Any other word, and any word presented with op_valid low, produces no output pulse and leaves every register unchanged.
- R2: In wide mode (wide_mode=1), a move-from returns bits 63:32 of register fs, sign-extended to 64 bits, with res_rt = rt.
- R3: In wide mode, a move-to writes gpr_word into bits 63:32 of fs and leaves bits 31:0 of fs unchanged.
- R4: In paired mode (wide_mode=0) with an even fs, a move-from returns bits 31:0 of register fs+1, sign-extended.
- R5: In paired mode with an even fs, a move-to writes gpr_word into bits 31:0 of register fs+1 and leaves bits 63:32 of that register unchanged.
- R6: In paired mode with an odd fs, a move-from returns 0x000000000BADF00D and raises poison for that one result cycle.
- R7: In paired mode with an odd fs, a move-to writes 0xDEADC0DE into bits 31:0 of register fs, raises poison for one cycle, and raises no res_valid.
- R8: With fpu_en low, an accepted word raises cop_unusable for one cycle. It produces no res_valid and no poison, and it writes no register.
- R9: While rst is high and after it is released, all outputs are low and every register reads as zero.
- R10: Outputs appear in the cycle after the op is presented. A write is visible to a move-from issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| gpr_word | input | 32 | Low 32 bits of the integer source operand |
| wide_mode | input | 1 | 1 = 64-bit register mode, 0 = paired 32-bit mode |
| fpu_en | input | 1 | FPU usable |
| res_valid | output | 1 | Move-from result is valid |
| res_rt | output | 5 | Destination integer register of the result |
| res_data | output | 64 | Sign-extended result |
| poison | output | 1 | Odd-register case in paired mode occurred |
| cop_unusable | output | 1 | Accepted op was refused because the FPU is disabled |

## Verification
The hardest effect to observe is where a poison write lands. In paired mode an odd register's low half can only be read back through a move-from on the even register below it. Wide mode never exposes that half. The stimulus therefore stores poison through an odd register in paired mode, then reads the even neighbour in paired mode and the same register in wide mode. Together these show that the low half changed and the high half did not. Random traffic mixes both modes, even and odd register numbers, disabled-FPU ops and corrupted encodings on a small register set, so reads often hit registers written a cycle earlier.

// File: rtl/hmove_pkg.sv
package hmove_pkg;

    localparam int WORD_W   = 64;
    localparam int HALF_W   = 32;
    localparam int REG_CNT  = 32;
    localparam int IDX_W    = $clog2(REG_CNT);

    localparam logic [5:0]        MAJOR_COP1  = 6'b010001;
    localparam logic [4:0]        SUB_FROM_HI = 5'b00011;
    localparam logic [4:0]        SUB_TO_HI   = 5'b00111;
    localparam logic [HALF_W-1:0] POISON_READ  = 32'h0BADF00D;
    localparam logic [HALF_W-1:0] POISON_WRITE = 32'hDEADC0DE;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_FROM = 2'd1,
        MV_TO   = 2'd2
    } mv_kind_e;

    typedef enum logic [1:0] {
        LOC_WIDE   = 2'd0,
        LOC_PAIR   = 2'd1,
        LOC_POISON = 2'd2
    } hi_loc_e;

    typedef struct packed {
        mv_kind_e         kind;
        logic [IDX_W-1:0] rt;
        logic [IDX_W-1:0] fs;
    } mv_op_t;

    function automatic logic [WORD_W-1:0] sext_half(input logic [HALF_W-1:0] v);
        return {{(WORD_W-HALF_W){v[HALF_W-1]}}, v};
    endfunction

endpackage

// File: rtl/hmove_decode.sv
module hmove_decode
    import hmove_pkg::*;
(
    input  logic        op_valid,
    input  logic [31:0] instr,
    output mv_op_t      op
);
    logic shape_ok;

    // R1: fixed major opcode and zero tail qualify the word
    always_comb begin
        shape_ok = op_valid && (instr[31:26] == MAJOR_COP1) && (instr[10:0] == 11'd0);
        op.rt    = instr[20:16];
        op.fs    = instr[15:11];
        op.kind  = MV_NONE;
        if (shape_ok) begin
            unique case (instr[25:21])
                SUB_FROM_HI: op.kind = MV_FROM;
                SUB_TO_HI:   op.kind = MV_TO;
                default:     op.kind = MV_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hmove_fpr_file.sv
module hmove_fpr_file #(
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 64,
    parameter int SEG_W   = 32,
    localparam int AW     = $clog2(ENTRIES),
    localparam int SEGS   = DATA_W / SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [SEGS-1:0]   wseg,
    input  logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] mem [ENTRIES];

    assign rdata = mem[raddr];

    // R9 reset clears every entry; R3/R5 only selected segments are written
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            for (int s = 0; s < SEGS; s++) begin
                if (wseg[s]) mem[waddr][s*SEG_W +: SEG_W] <= wdata[s*SEG_W +: SEG_W];
            end
        end
    end

    // Snapshot of the entry before a write, used to prove untouched segments hold
    logic [DATA_W-1:0] snap_q;
    logic [SEGS-1:0]   snap_keep_q;
    logic [AW-1:0]     snap_idx_q;
    logic              snap_chk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q      <= '0;
            snap_keep_q <= '0;
            snap_idx_q  <= '0;
            snap_chk_q  <= 1'b0;
        end else begin
            snap_q      <= mem[waddr];
            snap_keep_q <= ~wseg;
            snap_idx_q  <= waddr;
            snap_chk_q  <= we;
        end
    end

    for (genvar g = 0; g < SEGS; g++) begin : g_keep
        // R3 / R5: a segment outside the write mask keeps its old value
        a_r3_r5_seg_kept: assert property (@(posedge clk) disable iff (rst)
            (snap_chk_q && snap_keep_q[g]) |->
                (mem[snap_idx_q][g*SEG_W +: SEG_W] == snap_q[g*SEG_W +: SEG_W]));
    end
endmodule

// File: rtl/hmove_route.sv
module hmove_route
    import hmove_pkg::*;
(
    input  mv_op_t             op,
    input  logic               wide_mode,
    input  logic               fpu_en,
    input  logic [WORD_W-1:0]  rdata,
    input  logic [HALF_W-1:0]  gpr_word,
    output logic [IDX_W-1:0]   raddr,
    output logic               we,
    output logic [IDX_W-1:0]   waddr,
    output logic [1:0]         wseg,
    output logic [WORD_W-1:0]  wdata,
    output logic               res_fire,
    output logic [WORD_W-1:0]  res_value,
    output logic               poison_now,
    output logic               unusable_now
);
    hi_loc_e            loc;
    logic [IDX_W-1:0]   pair_idx;
    logic               usable;

    always_comb begin
        pair_idx = op.fs | IDX_W'(1);
        if (wide_mode)        loc = LOC_WIDE;
        else if (op.fs[0])    loc = LOC_POISON;
        else                  loc = LOC_PAIR;
    end

    always_comb begin
        usable       = fpu_en && (op.kind != MV_NONE);
        unusable_now = !fpu_en && (op.kind != MV_NONE);   // R8
        raddr        = (loc == LOC_PAIR) ? pair_idx : op.fs;
        we           = 1'b0;
        waddr        = op.fs;
        wseg         = 2'b00;
        wdata        = {gpr_word, gpr_word};
        res_fire     = 1'b0;
        res_value    = '0;
        poison_now   = 1'b0;

        if (usable && op.kind == MV_FROM) begin
            res_fire = 1'b1;
            unique case (loc)
                LOC_WIDE:   res_value = sext_half(rdata[WORD_W-1:HALF_W]);  // R2
                LOC_PAIR:   res_value = sext_half(rdata[HALF_W-1:0]);       // R4
                default: begin
                    res_value  = sext_half(POISON_READ);                     // R6
                    poison_now = 1'b1;
                end
            endcase
        end else if (usable && op.kind == MV_TO) begin
            we = 1'b1;
            unique case (loc)
                LOC_WIDE: begin                                              // R3
                    waddr = op.fs;
                    wseg  = 2'b10;
                end
                LOC_PAIR: begin                                              // R5
                    waddr = pair_idx;
                    wseg  = 2'b01;
                end
                default: begin                                               // R7
                    waddr      = op.fs;
                    wseg       = 2'b01;
                    wdata      = {POISON_WRITE, POISON_WRITE};
                    poison_now = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/hmove_unit.sv
module hmove_unit
    import hmove_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [31:0] instr,
    input  logic [31:0] gpr_word,
    input  logic        wide_mode,
    input  logic        fpu_en,
    output logic        res_valid,
    output logic [4:0]  res_rt,
    output logic [63:0] res_data,
    output logic        poison,
    output logic        cop_unusable
);
    mv_op_t            op;
    logic [IDX_W-1:0]  raddr;
    logic [WORD_W-1:0] rdata;
    logic              we;
    logic [IDX_W-1:0]  waddr;
    logic [1:0]        wseg;
    logic [WORD_W-1:0] wdata;
    logic              res_fire;
    logic [WORD_W-1:0] res_value;
    logic              poison_now;
    logic              unusable_now;

    hmove_decode u_decode (
        .op_valid (op_valid),
        .instr    (instr),
        .op       (op)
    );

    hmove_fpr_file #(
        .ENTRIES (REG_CNT),
        .DATA_W  (WORD_W),
        .SEG_W   (HALF_W)
    ) u_fpr (
        .clk   (clk),
        .rst   (rst),
        .raddr (raddr),
        .rdata (rdata),
        .we    (we),
        .waddr (waddr),
        .wseg  (wseg),
        .wdata (wdata)
    );

    hmove_route u_route (
        .op           (op),
        .wide_mode    (wide_mode),
        .fpu_en       (fpu_en),
        .rdata        (rdata),
        .gpr_word     (gpr_word),
        .raddr        (raddr),
        .we           (we),
        .waddr        (waddr),
        .wseg         (wseg),
        .wdata        (wdata),
        .res_fire     (res_fire),
        .res_value    (res_value),
        .poison_now   (poison_now),
        .unusable_now (unusable_now)
    );

    // R10: one register stage between the op and its outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            res_rt       <= '0;
            res_data     <= '0;
            poison       <= 1'b0;
            cop_unusable <= 1'b0;
        end else begin
            res_valid    <= res_fire;
            res_rt       <= res_fire ? op.rt : '0;
            res_data     <= res_fire ? res_value : '0;
            poison       <= poison_now;
            cop_unusable <= unusable_now;
        end
    end

    // R1: no op presented, no pulse in the following cycle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !poison && !cop_unusable));

    // R8: a refused op comes with no result and no poison
    a_r8_refusal_alone: assert property (@(posedge clk) disable iff (rst)
        cop_unusable |-> (!res_valid && !poison));

    // R6: a poisoned result carries the fixed read pattern
    a_r6_poison_pattern: assert property (@(posedge clk) disable iff (rst)
        (res_valid && poison) |-> (res_data == 64'h000000000BADF00D));

    // R2 / R4: every result is a sign-extended 32-bit value
    a_r2_sign_extended: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_data[63:32] == {32{res_data[31]}}));

    // R9: outputs stay low the cycle after reset is held
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !poison && !cop_unusable && res_data == 64'd0));
endmodule

// File: tb/hmove_unit_bench.sv
module hmove_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [31:0] instr;
    logic [31:0] gpr_word;
    logic        wide_mode;
    logic        fpu_en;
    logic        res_valid;
    logic [4:0]  res_rt;
    logic [63:0] res_data;
    logic        poison;
    logic        cop_unusable;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    hmove_unit u_hmove_unit (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .instr        (instr),
        .gpr_word     (gpr_word),
        .wide_mode    (wide_mode),
        .fpu_en       (fpu_en),
        .res_valid    (res_valid),
        .res_rt       (res_rt),
        .res_data     (res_data),
        .poison       (poison),
        .cop_unusable (cop_unusable)
    );

    function automatic logic [31:0] enc(input logic [4:0] sub, input logic [4:0] rt, input logic [4:0] fs);
        return {6'b010001, sub, rt, fs, 11'd0};
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // Drives one op at a falling edge, predicts from the model, checks after the next rising edge
    task automatic run_op(input logic v, input logic [31:0] ins, input logic [31:0] g,
                          input logic wm, input logic en);
        logic        legal, from;
        logic [4:0]  fs;
        logic        e_rv, e_p, e_cu;
        logic [63:0] e_data;
        string       tag;
        fs    = ins[15:11];
        from  = (ins[25:21] == 5'b00011);
        legal = v && ins[31:26] == 6'b010001 && ins[10:0] == 11'd0 &&
                (from || ins[25:21] == 5'b00111);
        e_rv = 0; e_p = 0; e_cu = 0; e_data = '0; tag = "R1";
        if (legal) begin
            if (!en) begin
                e_cu = 1; tag = "R8";
            end else if (from) begin
                e_rv = 1;
                if (wm)          begin e_data = sx(model[fs][63:32]);     tag = "R2"; end
                else if (!fs[0]) begin e_data = sx(model[fs | 5'd1][31:0]); tag = "R4"; end
                else             begin e_data = sx(32'h0BADF00D); e_p = 1; tag = "R6"; end
            end else begin
                if (wm)          begin model[fs][63:32] = g;           tag = "R3"; end
                else if (!fs[0]) begin model[fs | 5'd1][31:0] = g;     tag = "R5"; end
                else             begin model[fs][31:0] = 32'hDEADC0DE; e_p = 1; tag = "R7"; end
            end
        end
        op_valid  = v;
        instr     = ins;
        gpr_word  = g;
        wide_mode = wm;
        fpu_en    = en;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk(res_valid == e_rv, {tag, " res_valid (R10)"}, 64'(res_valid), 64'(e_rv));
        if (e_rv) begin
            chk(res_data == e_data, {tag, " res_data"}, res_data, e_data);
            chk(res_rt == ins[20:16], {tag, " res_rt"}, 64'(res_rt), 64'(ins[20:16]));
        end
        chk(poison == e_p, {tag, " poison"}, 64'(poison), 64'(e_p));
        chk(cop_unusable == e_cu, {tag, " cop_unusable"}, 64'(cop_unusable), 64'(e_cu));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst = 1'b1; op_valid = 1'b0; instr = '0; gpr_word = '0; wide_mode = 1'b1; fpu_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs low during reset
        chk(!res_valid && !poison && !cop_unusable && res_data == 64'd0, "R9 outputs in reset",
            res_data, 64'd0);
        rst = 1'b0;

        // R9: every register reads zero in both modes
        for (int r = 0; r < 32; r++) run_op(1, enc(5'b00011, 5'(r), 5'(r)), 32'd0, 1, 1);
        for (int r = 0; r < 32; r += 2) run_op(1, enc(5'b00011, 5'd1, 5'(r)), 32'd0, 0, 1);

        // R3 then R2, back to back (R10)
        run_op(1, enc(5'b00111, 5'd0, 5'd3), 32'h87654321, 1, 1);
        run_op(1, enc(5'b00011, 5'd4, 5'd3), 32'd0, 1, 1);
        // R5 then R4, then wide read shows the upper half untouched
        run_op(1, enc(5'b00111, 5'd0, 5'd6), 32'h7ABCDEF0, 0, 1);
        run_op(1, enc(5'b00011, 5'd9, 5'd6), 32'd0, 0, 1);
        run_op(1, enc(5'b00011, 5'd9, 5'd7), 32'd0, 1, 1);
        // R3: wide write of reg 7 keeps the low half seen through pair read of 6
        run_op(1, enc(5'b00111, 5'd0, 5'd7), 32'h80000001, 1, 1);
        run_op(1, enc(5'b00011, 5'd2, 5'd6), 32'd0, 0, 1);
        run_op(1, enc(5'b00011, 5'd2, 5'd7), 32'd0, 1, 1);
        // R6: odd read in paired mode
        run_op(1, enc(5'b00011, 5'd31, 5'd9), 32'd0, 0, 1);
        // R7: odd write lands in the low half of reg 9; read via 8 (pair) and 9 (wide)
        run_op(1, enc(5'b00111, 5'd0, 5'd9), 32'h12345678, 0, 1);
        run_op(1, enc(5'b00011, 5'd5, 5'd8), 32'd0, 0, 1);
        run_op(1, enc(5'b00011, 5'd5, 5'd9), 32'd0, 1, 1);
        // R8: disabled FPU refuses and writes nothing
        run_op(1, enc(5'b00111, 5'd0, 5'd3), 32'hFFFF0000, 1, 0);
        run_op(1, enc(5'b00011, 5'd0, 5'd3), 32'd0, 1, 0);
        run_op(1, enc(5'b00011, 5'd0, 5'd3), 32'd0, 1, 1);
        // R1: corrupted encodings and an unvalidated op are ignored
        run_op(1, enc(5'b00111, 5'd0, 5'd3) | 32'd1, 32'h0000AAAA, 1, 1);
        run_op(1, enc(5'b00111, 5'd0, 5'd3) ^ 32'h0400_0000, 32'h0000BBBB, 1, 1);
        run_op(1, enc(5'b00101, 5'd0, 5'd3), 32'h0000CCCC, 1, 1);
        run_op(0, enc(5'b00111, 5'd0, 5'd3), 32'h0000DDDD, 1, 1);
        run_op(1, enc(5'b00011, 5'd1, 5'd3), 32'd0, 1, 1);

        // Random mix on a narrow register window so reads hit recent writes
        for (int k = 0; k < 1500; k++) begin
            logic [4:0]  fs, rt, sub;
            logic [31:0] w;
            fs  = 5'($urandom_range(0, 7)) + ((($urandom % 4) == 0) ? 5'd24 : 5'd0);
            rt  = 5'($urandom);
            sub = ($urandom % 2) ? 5'b00011 : 5'b00111;
            w   = enc(sub, rt, fs);
            if (($urandom % 16) == 0) w = w ^ (32'd1 << $urandom_range(0, 31));
            run_op(($urandom % 16) != 0, w, $urandom, 1'($urandom), ($urandom % 12) != 0);
        end

        summary();
        $finish;
    end
endmodule